// File: doc/BRIEF.md
# Flash Command and Status Sequencer

This block models the command and status front end of a small on-chip flash array as seen from an 8-bit microcontroller bus. The array cannot be written like RAM. A byte is programmed only after a fixed unlock sequence of bus writes. The whole array is erased only after a longer unlock sequence. Programming can only clear bits. Erase returns every byte to 0xFF.

Each bus write is framed by an active-low write strobe. The block samples that strobe on its clock. It takes the address when the strobe falls and the data when the strobe rises. Once a command is accepted, a timed internal busy phase stands in for the cell physics. During that phase the ready output is low, and reads return a status byte instead of array contents:

- bit 7 is a polling bit.
- bit 6 toggles on every read.
- bit 5 flags failure.

A program that would have to raise a bit from 0 to 1 fails. After its busy phase, the block holds the failure status until reset. An active-low reset aborts any operation, returns the block to read mode and leaves the array untouched.

Top module: `flash_status_seq`

## Requirements
- R1: After reset, rdy_o is 1, rdata_o is 0x00, and the block is in read mode, where a read (rd_i high for one cycle) returns the addressed byte in rdata_o on the following cycle.
- R2: The writes 0xAA to address 0x555, 0x55 to 0x2AA and 0xA0 to 0x555, followed by one write of data D to address A, replace the byte at A (index = low address bits) with old & D when the busy phase ends.
- R3: The target address of a write is the value on addr_i when we_ni falls. The data is the value on wdata_i when we_ni rises.
- R4: rdy_o goes low on the cycle after the final write of a sequence is registered. It stays low for exactly BUSY_CYCLES cycles when the operation succeeds.
- R5: While rdy_o is 0, bit 6 of successive read results alternates.
- R6: During a program, bit 7 of a status read is the complement of bit 7 of D. After completion, a read of A returns the true data.
- R7: The sequence 0xAA@0x555, 0x55@0x2AA, 0x80@0x555, 0xAA@0x555, 0x55@0x2AA, 0x10@0x555 erases every byte to 0xFF. Status reads during the erase show bit 7 = 0.
- R8: A program whose data has a 1 where the stored byte has a 0 leaves the byte unchanged. After the busy phase it keeps rdy_o at 0, and status reads show bit 5 = 1 until reset.
- R9: A write that does not match the next expected unlock address/data pair returns the block to read mode; no operation starts.
- R10: Asserting rst_ni during a busy phase aborts it. rdy_o returns to 1 and the target byte keeps its old value.
- R11: Writes issued while rdy_o is 0 are ignored and start no new operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset; aborts any operation |
| addr_i | input | ADDR_W | Bus address |
| wdata_i | input | 8 | Bus write data |
| we_ni | input | 1 | Active-low write strobe, sampled on clk_i |
| rd_i | input | 1 | One-cycle read request |
| rdata_o | output | 8 | Read result: array byte, or status while busy |
| rdy_o | output | 1 | 1 = ready, 0 = program/erase in progress or failed |

## Verification
The failed-program state is the hardest to reach. It can only be entered by a correctly unlocked program whose data tries to raise a cleared bit, so the stimulus first programs a byte to 0x00 and then programs 0x01 into it. The bench waits past the full busy window and then confirms that ready stays low, that bit 5 is set, and that only a reset leaves the state. Abort is reached the same way: the bench issues a reset a few cycles into a valid program's busy phase, then re-reads the byte long after the phase would have ended.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
  localparam int unsigned DW = 8;

  localparam logic [DW-1:0] CMD_UNLK1 = 8'hAA;
  localparam logic [DW-1:0] CMD_UNLK2 = 8'h55;
  localparam logic [DW-1:0] CMD_PGM   = 8'hA0;
  localparam logic [DW-1:0] CMD_ERS   = 8'h80;
  localparam logic [DW-1:0] CMD_CHIP  = 8'h10;

  typedef enum logic [3:0] {
    ST_READ,
    ST_U1,
    ST_U2,
    ST_PGM,
    ST_E1,
    ST_E2,
    ST_E3,
    ST_BUSY,
    ST_FAIL
  } seq_state_e;
endpackage

// File: rtl/flash_strobe_cap.sv
module flash_strobe_cap #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              stb_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o
);
  logic we_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_q   <= 1'b1;
      stb_o  <= 1'b0;
      addr_o <= '0;
      data_o <= '0;
    end else begin
      we_q  <= we_ni;
      stb_o <= 1'b0;
      if (we_q && !we_ni) addr_o <= addr_i;   // falling edge: address
      if (!we_q && we_ni) begin               // rising edge: data, cycle done
        data_o <= wdata_i;
        stb_o  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/flash_busy_timer.sv
module flash_busy_timer #(
  parameter int unsigned CYCLES = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic done_o
);
  localparam int unsigned CNT_W = $clog2(CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             act_q;

  assign done_o = act_q && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (load_i) begin
      cnt_q <= CNT_W'(CYCLES - 1);
      act_q <= 1'b1;
    end else if (act_q) begin
      if (cnt_q == '0) act_q <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
  import flash_seq_pkg::*;
#(
  parameter int unsigned       ADDR_W   = 12,
  parameter logic [ADDR_W-1:0] UNLOCK_A = 12'h555,
  parameter logic [ADDR_W-1:0] UNLOCK_B = 12'h2AA
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stb_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     data_i,
  input  logic              done_i,
  input  logic              bad_i,
  output seq_state_e        state_o,
  output logic              start_pgm_o,
  output logic              start_ers_o,
  output logic              commit_o
);
  seq_state_e st_q, st_d;

  logic hit_a, hit_b;
  assign hit_a = (addr_i == UNLOCK_A);
  assign hit_b = (addr_i == UNLOCK_B);

  always_comb begin
    st_d        = st_q;
    start_pgm_o = 1'b0;
    start_ers_o = 1'b0;
    commit_o    = 1'b0;
    unique case (st_q)
      ST_BUSY: if (done_i) begin
        st_d     = bad_i ? ST_FAIL : ST_READ;
        commit_o = !bad_i;
      end
      ST_FAIL: st_d = ST_FAIL;
      default: if (stb_i) begin
        st_d = ST_READ;  // any mismatch falls back to read mode
        unique case (st_q)
          ST_READ: if (hit_a && data_i == CMD_UNLK1) st_d = ST_U1;
          ST_U1:   if (hit_b && data_i == CMD_UNLK2) st_d = ST_U2;
          ST_U2:   if (hit_a && data_i == CMD_PGM)   st_d = ST_PGM;
                   else if (hit_a && data_i == CMD_ERS) st_d = ST_E1;
          ST_PGM: begin
            st_d        = ST_BUSY;
            start_pgm_o = 1'b1;
          end
          ST_E1:   if (hit_a && data_i == CMD_UNLK1) st_d = ST_E2;
          ST_E2:   if (hit_b && data_i == CMD_UNLK2) st_d = ST_E3;
          ST_E3:   if (hit_a && data_i == CMD_CHIP) begin
            st_d        = ST_BUSY;
            start_ers_o = 1'b1;
          end
          default: st_d = ST_READ;
        endcase
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_READ;
    else         st_q <= st_d;
  end

  assign state_o = st_q;
endmodule

// File: rtl/flash_status_seq.sv
module flash_status_seq
  import flash_seq_pkg::*;
#(
  parameter int unsigned       ADDR_W      = 12,
  parameter int unsigned       DEPTH       = 16,
  parameter int unsigned       BUSY_CYCLES = 8,
  parameter logic [ADDR_W-1:0] UNLOCK_A    = 12'h555,
  parameter logic [ADDR_W-1:0] UNLOCK_B    = 12'h2AA
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              we_ni,
  input  logic              rd_i,
  output logic [DW-1:0]     rdata_o,
  output logic              rdy_o
);
  localparam int unsigned IDX_W = $clog2(DEPTH);

  logic              cap_stb;
  logic [ADDR_W-1:0] cap_addr;
  logic [DW-1:0]     cap_data;
  logic              tmr_done, start_pgm, start_ers, commit;
  seq_state_e        state;

  logic [DW-1:0]    mem_q [DEPTH];
  logic [IDX_W-1:0] op_idx_q;
  logic [DW-1:0]    op_data_q;
  logic             op_ers_q, op_bad_q, tog_q;
  logic             st_fail;

  flash_strobe_cap #(.ADDR_W(ADDR_W), .DATA_W(DW)) u_cap (
    .clk_i, .rst_ni, .we_ni, .addr_i, .wdata_i,
    .stb_o(cap_stb), .addr_o(cap_addr), .data_o(cap_data)
  );

  flash_cmd_fsm #(.ADDR_W(ADDR_W), .UNLOCK_A(UNLOCK_A), .UNLOCK_B(UNLOCK_B)) u_fsm (
    .clk_i, .rst_ni, .stb_i(cap_stb), .addr_i(cap_addr), .data_i(cap_data),
    .done_i(tmr_done), .bad_i(op_bad_q), .state_o(state),
    .start_pgm_o(start_pgm), .start_ers_o(start_ers), .commit_o(commit)
  );

  flash_busy_timer #(.CYCLES(BUSY_CYCLES)) u_tmr (
    .clk_i, .rst_ni, .load_i(start_pgm | start_ers), .done_o(tmr_done)
  );

  assign st_fail = (state == ST_FAIL);
  assign rdy_o   = (state != ST_BUSY) && !st_fail;

  // operation context, captured when a command is accepted
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_idx_q  <= '0;
      op_data_q <= '1;
      op_ers_q  <= 1'b0;
      op_bad_q  <= 1'b0;
    end else if (start_pgm) begin
      op_idx_q  <= cap_addr[IDX_W-1:0];
      op_data_q <= cap_data;
      op_ers_q  <= 1'b0;
      op_bad_q  <= |(cap_data & ~mem_q[cap_addr[IDX_W-1:0]]);
    end else if (start_ers) begin
      op_data_q <= '1;
      op_ers_q  <= 1'b1;
      op_bad_q  <= 1'b0;
    end
  end

  // array content survives reset
  always_ff @(posedge clk_i) begin
    if (commit) begin
      if (op_ers_q) begin
        for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
      end else begin
        mem_q[op_idx_q] <= mem_q[op_idx_q] & op_data_q;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
      tog_q   <= 1'b0;
    end else begin
      if (start_pgm || start_ers) tog_q <= 1'b0;
      else if (rd_i && !rdy_o)    tog_q <= ~tog_q;
      if (rd_i) begin
        if (rdy_o) rdata_o <= mem_q[addr_i[IDX_W-1:0]];
        else       rdata_o <= {~op_data_q[DW-1], tog_q, st_fail, 5'b0};
      end
    end
  end
endmodule

// File: rtl/flash_status_seq_chk.sv
module flash_status_seq_chk #(
  parameter int unsigned BUSY_CYCLES = 8
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       rd_i,
  input logic       rdy_o,
  input logic [7:0] rdata_o,
  input logic       fail_i,
  input logic       ers_i,
  input logic [7:0] op_data_i
);
  logic [15:0] low_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              low_cnt <= '0;
    else if (rdy_o)           low_cnt <= '0;
    else if (low_cnt != '1)   low_cnt <= low_cnt + 1'b1;
  end

  assert_busy_len_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rdy_o && !fail_i) |-> (low_cnt < 16'(BUSY_CYCLES)));

  assert_toggle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !rdy_o && $past(rd_i && !rdy_o)) |=> (rdata_o[6] != $past(rdata_o[6])));

  assert_poll_bit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !rdy_o && !ers_i) |=> (rdata_o[7] == ~op_data_i[7]));

  assert_erase_poll_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !rdy_o && ers_i) |=> !rdata_o[7]);

  assert_fail_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_i |=> (fail_i && !rdy_o));
endmodule

bind flash_status_seq flash_status_seq_chk #(.BUSY_CYCLES(BUSY_CYCLES)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rd_i(rd_i), .rdy_o(rdy_o), .rdata_o(rdata_o),
  .fail_i(st_fail), .ers_i(op_ers_q), .op_data_i(op_data_q)
);

// File: tb/flash_status_seq_tb_top.sv
module flash_status_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int BUSY_CYC   = 20;
  localparam int AW         = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0]    wdata = '0;
  logic          we_n = 1'b1;
  logic          rd = 1'b0;
  logic [7:0]    rdata;
  logic          rdy;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_status_seq #(.ADDR_W(AW), .DEPTH(16), .BUSY_CYCLES(BUSY_CYC)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
    .we_ni(we_n), .rd_i(rd), .rdata_o(rdata), .rdy_o(rdy)
  );

  // {addr[3:0], data, expected byte after program}
  localparam logic [19:0] VEC [6] = '{
    {4'h3, 8'h5A, 8'h5A},
    {4'h3, 8'h4A, 8'h4A},
    {4'h0, 8'hA5, 8'hA5},
    {4'hF, 8'h00, 8'h00},
    {4'h7, 8'hF0, 8'hF0},
    {4'h7, 8'h30, 8'h30}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; we_n = 1'b0;
    @(negedge clk); we_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic rd_byte(input logic [AW-1:0] a, output logic [7:0] q);
    @(negedge clk); addr = a; rd = 1'b1;
    @(negedge clk); rd = 1'b0; q = rdata;
  endtask

  task automatic pgm(input logic [AW-1:0] a, input logic [7:0] d);
    wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(12'h555, 8'hA0); wr(a, d);
  endtask

  task automatic wait_rdy();
    for (int i = 0; i < 1000 && !rdy; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    logic [7:0] q, q2;
    int lows;
    bit all_ff;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready after reset", {7'b0, rdy}, 8'h01);
    chk("R1 rdata after reset", rdata, 8'h00);

    // R7 erase
    wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(12'h555, 8'h80);
    wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(12'h555, 8'h10);
    rd_byte(12'h0, q);
    chk("R7 erase status bit7", {7'b0, q[7]}, 8'h00);
    wait_rdy();
    all_ff = 1;
    for (int i = 0; i < 16; i++) begin
      rd_byte(AW'(i), q);
      if (q !== 8'hFF) all_ff = 0;
    end
    chk("R7 all bytes FF after erase", {7'b0, all_ff}, 8'h01);

    // table walk: R2 result, R6 polling, R5 toggle
    for (int v = 0; v < 6; v++) begin
      pgm({8'h0, VEC[v][19:16]}, VEC[v][15:8]);
      rd_byte(12'h0, q);
      rd_byte(12'h0, q2);
      chk("R6 status bit7 complement", {7'b0, q[7]}, {7'b0, ~VEC[v][15]});
      chk("R5 bit6 toggles", {7'b0, q[6] ^ q2[6]}, 8'h01);
      wait_rdy();
      rd_byte({8'h0, VEC[v][19:16]}, q);
      chk("R2 R6 programmed byte", q, VEC[v][7:0]);
    end

    // R4 busy length
    pgm(12'h002, 8'h77);
    lows = 0;
    for (int i = 0; i < 100 && !rdy; i++) begin lows++; @(negedge clk); end
    chk("R4 busy cycles", 8'(lows), 8'(BUSY_CYC));
    rd_byte(12'h002, q);
    chk("R4 byte after busy", q, 8'h77);

    // R3 address on falling edge, data on rising edge
    wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(12'h555, 8'hA0);
    @(negedge clk); addr = 12'h00C; wdata = 8'hFF; we_n = 1'b0;
    @(negedge clk); addr = 12'h001; wdata = 8'h3C; we_n = 1'b1;
    repeat (2) @(negedge clk);
    wait_rdy();
    rd_byte(12'h00C, q);
    chk("R3 data at rise, addr at fall", q, 8'h3C);
    rd_byte(12'h001, q);
    chk("R3 late address untouched", q, 8'hFF);

    // R9 mismatched unlock
    wr(12'h555, 8'hAA); wr(12'h2AA, 8'h12); wr(12'h555, 8'hA0); wr(12'h005, 8'h00);
    chk("R9 no op after bad data", {7'b0, rdy}, 8'h01);
    wr(12'h555, 8'hAA); wr(12'h123, 8'h55); wr(12'h555, 8'hA0); wr(12'h005, 8'h00);
    chk("R9 no op after bad addr", {7'b0, rdy}, 8'h01);
    rd_byte(12'h005, q);
    chk("R9 byte unchanged", q, 8'hFF);

    // R11 writes while busy ignored
    pgm(12'h004, 8'hEE);
    pgm(12'h009, 8'h00);
    wait_rdy();
    repeat (3) @(negedge clk);
    chk("R11 no new op", {7'b0, rdy}, 8'h01);
    rd_byte(12'h009, q);
    chk("R11 byte unchanged", q, 8'hFF);
    rd_byte(12'h004, q);
    chk("R11 first op done", q, 8'hEE);

    // R8 failing program: 0x00 -> 0x01
    pgm(12'h00F, 8'h01);
    repeat (BUSY_CYC + 5) @(negedge clk);
    chk("R8 stays not ready", {7'b0, rdy}, 8'h00);
    rd_byte(12'h0, q);
    chk("R8 error bit5", {7'b0, q[5]}, 8'h01);
    do_reset();
    chk("R8 ready after reset", {7'b0, rdy}, 8'h01);
    rd_byte(12'h00F, q);
    chk("R8 byte unchanged", q, 8'h00);

    // R10 abort
    pgm(12'h000, 8'h05);
    repeat (3) @(negedge clk);
    do_reset();
    chk("R10 ready after abort", {7'b0, rdy}, 8'h01);
    repeat (BUSY_CYC + 2) @(negedge clk);
    rd_byte(12'h000, q);
    chk("R10 byte kept", q, 8'hA5);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule